// File: doc/BRIEF.md
# Local Bus Master Cycle Sequencer

This block turns a buffered transfer request into data-phase cycles on a parallel local bus. A request names one of several address spaces, a start address, a direction, a set of four byte enables shared by every word, and a word count. When the request is taken, the block loads that space's settings: data width, internal wait count, whether the external active-low ready input is honoured, and the burst style. It then steps through every beat with a byte enabled and drives address, byte enables, write data, an address strobe, a data strobe and a burst-last flag. On reads it puts the returned lanes back together into 32-bit words.

A 32-bit word goes out as one, two or four beats, depending on whether the space is 32, 16 or 8 bits wide. A narrow beat uses the low lanes of the bus. How the local bus bursts is set only by the space's own burst style and by whether the addresses run in sequence. It does not depend on how the requesting side delivers words. Write words are taken one at a time through a take strobe, and read words come back one at a time with a valid pulse.

Top module: `lbus_seq`

## Requirements
- R1: After reset, busy, lAddrStb, lDataStb, lBeatEnd, rdValid and wrTake are all low.
- R2: A start pulse with startBe equal to 0 or startWords equal to 0 is ignored. busy and both strobes stay low. An accepted start is followed, in the next cycle, by an address phase (lAddrStb high for one cycle).
- R3: Width code 2 (or 3) selects a 32-bit bus. Each word is one beat with lBe equal to startBe and lDataOut equal to the whole word. The beat address is the word address: startAddr with its two low bits cleared, plus 4 for each word.
- R4: Width code 1 selects a 16-bit bus. Each word becomes a low-halfword beat (lanes 0-1, offset 0) and then a high-halfword beat (lanes 2-3, offset 2). Each beat carries its halfword on lDataOut[15:0] with upper bits zero, and its two enables on lBe[1:0].
- R5: Width code 0 selects an 8-bit bus. Each word becomes byte beats for lanes 0, 1, 2, 3 in that order, at offsets 0 to 3. Each beat carries its byte on lDataOut[7:0] and its enable on lBe[0].
- R6: A narrow beat whose byte enables are all clear is skipped. When the next beat's address does not follow directly after the current one, the current address phase ends and a new one starts.
- R7: With ready disabled for the space, every beat holds lDataStb for exactly W+1 cycles, where W is the space's wait count, and lRdyN has no effect.
- R8: With ready enabled, a beat ends in the first data cycle in which W cycles have passed and lRdyN is sampled low. A beat whose ready goes low in data cycle d therefore lasts max(W,d)+1 cycles.
- R9: Burst code 2 (or 3), continuous: beats that follow each other in sequence share one address phase for the whole transfer.
- R10: Burst code 1, groups of four: an address phase covers at most four beats, and the fifth sequential beat starts a new address phase.
- R11: Burst code 0, single: every beat has its own address phase.
- R12: lBlast is high during the final beat of every address phase, including the last beat of the transfer, and low during every other beat.
- R13: On a read, rdValid pulses one cycle after the final beat of each word. rdData holds the returned bytes in their own lanes, with lanes whose enable is clear set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWidth | input | 2*NUM_SPACES | Per-space width code: 0 = 8, 1 = 16, 2/3 = 32 bit |
| cfgWait | input | WAIT_W*NUM_SPACES | Per-space internal wait count W |
| cfgRdyEn | input | NUM_SPACES | Per-space enable for lRdyN |
| cfgMode | input | 2*NUM_SPACES | Per-space burst code: 0 single, 1 groups of four, 2/3 continuous |
| start | input | 1 | Request pulse, taken when idle |
| startSpace | input | SPACE_W | Space index of the request |
| startAddr | input | ADDR_W | Start byte address; two low bits ignored |
| startWrite | input | 1 | 1 = write, 0 = read |
| startBe | input | 4 | Byte enables applied to every word |
| startWords | input | CNT_W | Number of 32-bit words |
| busy | output | 1 | Transfer in progress |
| wrData | input | 32 | Next write word, captured when wrTake is high |
| wrTake | output | 1 | wrData is captured at the coming edge |
| rdData | output | 32 | Assembled read word |
| rdValid | output | 1 | rdData valid for this cycle |
| lAddr | output | ADDR_W | Byte address of the current beat |
| lAddrStb | output | 1 | Address phase |
| lDataStb | output | 1 | Data phase |
| lBlast | output | 1 | Final beat of the address phase |
| lBeatEnd | output | 1 | The current beat completes at the coming edge |
| lWrite | output | 1 | Direction of the transfer |
| lBe | output | 4 | Byte enables of the current beat |
| lDataOut | output | 32 | Write data of the current beat |
| lDataIn | input | 32 | Read data of the current beat |
| lRdyN | input | 1 | External active-low ready |

## Verification
The bench runs every combination of width, burst style and direction against a set of byte-enable patterns. All lanes enabled shows the plain splitting and burst grouping. Patterns with holes (0101, 0110, 1000, 0011, 1100) show whether empty beats are skipped and whether a gap in the address restarts an address phase. The wait count and the ready setting change from run to run, and the requested space rotates while the other spaces hold different settings, so a wrong space lookup shows up. Ready is driven both earlier and later than the internal count expires, which tells the enabled and disabled cases apart. Longer continuous and groups-of-four bursts on the 8-bit bus show where a phase has to break.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  localparam logic [1:0] BW_8  = 2'd0;
  localparam logic [1:0] BW_16 = 2'd1;

  localparam logic [1:0] BM_SINGLE = 2'd0;
  localparam logic [1:0] BM_QUAD   = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} ctlState_t;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic beatEnd;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lastBeat;
    logic breakNext;
  } seqStatus_t;

  function automatic logic [2:0] beatsOf(logic [1:0] width);
    case (width)
      BW_8:    return 3'd4;
      BW_16:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // bus-side byte enables of one beat (narrow beats sit on the low lanes)
  function automatic logic [3:0] laneMask(logic [1:0] width, logic [3:0] be,
                                          logic [1:0] lane);
    case (width)
      BW_8:    return {3'b000, be[lane]};
      BW_16:   return lane[0] ? {2'b00, be[3:2]} : {2'b00, be[1:0]};
      default: return be;
    endcase
  endfunction

  function automatic logic [1:0] firstLane(logic [1:0] width, logic [3:0] be);
    logic [1:0] r;
    r = 2'd0;
    for (int j = 3; j >= 0; j--) begin
      if (3'(j) < beatsOf(width) && laneMask(width, be, 2'(j)) != 4'd0)
        r = 2'(j);
    end
    return r;
  endfunction

endpackage

// File: rtl/lbus_ctl.sv
module lbus_ctl
  import lbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              reqOk,
  input  logic [WAIT_W-1:0] selWait,
  input  logic              selRdyEn,
  input  logic [1:0]        selMode,
  input  logic              lRdyN,
  input  seqStatus_t        sts,
  output seqStrobe_t        stb,
  output logic              busy,
  output logic              lAddrStb,
  output logic              lDataStb,
  output logic              lBlast,
  output logic              lBeatEnd
);

  ctlState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLd;
  logic              rdyEnQ;
  logic [1:0]        modeQ;
  logic [1:0]        phaseCnt;

  logic accept;
  logic beatEnd;
  logic phaseLast;

  assign accept  = (state == S_IDLE) && start && reqOk;
  assign beatEnd = (state == S_DATA) && (waitCnt == '0) && (!rdyEnQ || !lRdyN);

  assign phaseLast = sts.lastBeat || sts.breakNext ||
                     (modeQ == BM_SINGLE) ||
                     ((modeQ == BM_QUAD) && (phaseCnt == 2'd3));

  assign stb.load    = accept;
  assign stb.beatEnd = beatEnd;

  assign busy     = (state != S_IDLE);
  assign lAddrStb = (state == S_ADDR);
  assign lDataStb = (state == S_DATA);
  assign lBlast   = (state == S_DATA) && phaseLast;
  assign lBeatEnd = beatEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      waitCnt  <= '0;
      waitLd   <= '0;
      rdyEnQ   <= 1'b0;
      modeQ    <= BM_SINGLE;
      phaseCnt <= 2'd0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            state    <= S_ADDR;
            waitLd   <= selWait;
            rdyEnQ   <= selRdyEn;
            modeQ    <= selMode;
            phaseCnt <= 2'd0;
          end
        end
        S_ADDR: begin
          state   <= S_DATA;
          waitCnt <= waitLd;
        end
        default: begin
          if (beatEnd) begin
            if (sts.lastBeat) begin
              state <= S_IDLE;
            end else if (phaseLast) begin
              state    <= S_ADDR;
              phaseCnt <= 2'd0;
            end else begin
              waitCnt  <= waitLd;
              phaseCnt <= phaseCnt + 2'd1;
            end
          end else if (waitCnt != '0) begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lbus_dp.sv
module lbus_dp
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  output seqStatus_t        sts,
  input  logic [1:0]        startWidth,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              startWrite,
  input  logic [3:0]        startBe,
  input  logic [CNT_W-1:0]  startWords,
  input  logic [31:0]       wrData,
  output logic              wrTake,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] lAddr,
  output logic              lWrite,
  output logic [3:0]        lBe,
  output logic [31:0]       lDataOut,
  input  logic [31:0]       lDataIn
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [1:0]        widthQ;
  logic [ADDR_W-1:0] baseQ;
  logic              writeQ;
  logic [3:0]        beQ;
  logic [CNT_W-1:0]  wordsQ;
  logic [CNT_W-1:0]  wordIdx;
  logic [1:0]        lane;
  logic [31:0]       wBuf;
  logic [31:0]       rBuf;
  logic [31:0]       rdDataQ;
  logic              rdValidQ;

  logic [2:0]  nBeats;
  logic [1:0]  firstL;
  logic        nextFound;
  logic [1:0]  nextLane;
  logic        lastWord;
  logic        wordEnd;
  logic [1:0]  byteOff;
  logic [31:0] rNext;
  logic [31:0] beExp;

  assign nBeats = beatsOf(widthQ);
  assign firstL = firstLane(widthQ, beQ);

  // smallest enabled lane above the current one in this word
  always_comb begin
    nextFound = 1'b0;
    nextLane  = lane;
    for (int j = 3; j >= 0; j--) begin
      if (3'(j) > {1'b0, lane} && 3'(j) < nBeats &&
          laneMask(widthQ, beQ, 2'(j)) != 4'd0) begin
        nextFound = 1'b1;
        nextLane  = 2'(j);
      end
    end
  end

  assign lastWord = (wordIdx == wordsQ - CNT_W'(1));
  assign wordEnd  = stb.beatEnd && !nextFound;

  assign sts.lastBeat  = lastWord && !nextFound;
  assign sts.breakNext = nextFound ? (nextLane != lane + 2'd1)
                                   : !(({1'b0, lane} == nBeats - 3'd1) && (firstL == 2'd0));

  always_comb begin
    case (widthQ)
      BW_8:    byteOff = lane;
      BW_16:   byteOff = {lane[0], 1'b0};
      default: byteOff = 2'd0;
    endcase
  end

  assign lAddr  = baseQ + ADDR_W'({wordIdx, 2'b00}) + ADDR_W'(byteOff);
  assign lBe    = laneMask(widthQ, beQ, lane);
  assign lWrite = writeQ;

  always_comb begin
    case (widthQ)
      BW_8:    lDataOut = {24'd0, wBuf[8*lane +: 8]};
      BW_16:   lDataOut = {16'd0, lane[0] ? wBuf[31:16] : wBuf[15:0]};
      default: lDataOut = wBuf;
    endcase
    if (!writeQ) lDataOut = 32'd0;
  end

  // place the incoming beat into its lanes of the word being built
  always_comb begin
    rNext = rBuf;
    for (int b = 0; b < 4; b++) begin
      case (widthQ)
        BW_8:    if (2'(b) == lane) rNext[8*b +: 8] = lDataIn[7:0];
        BW_16:   if (b[1] == lane[0]) rNext[8*b +: 8] = lDataIn[8*(b%2) +: 8];
        default: rNext[8*b +: 8] = lDataIn[8*b +: 8];
      endcase
    end
  end

  assign beExp  = {{8{beQ[3]}}, {8{beQ[2]}}, {8{beQ[1]}}, {8{beQ[0]}}};
  assign wrTake = stb.load ? startWrite : (wordEnd && writeQ && !lastWord);

  assign rdData  = rdDataQ;
  assign rdValid = rdValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthQ   <= 2'd0;
      baseQ    <= '0;
      writeQ   <= 1'b0;
      beQ      <= 4'd0;
      wordsQ   <= '0;
      wordIdx  <= '0;
      lane     <= 2'd0;
      wBuf     <= 32'd0;
      rBuf     <= 32'd0;
      rdDataQ  <= 32'd0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= stb.beatEnd && wordEnd && !writeQ;
      if (stb.beatEnd && wordEnd && !writeQ) rdDataQ <= rNext & beExp;
      if (stb.load) begin
        widthQ  <= startWidth;
        baseQ   <= startAddr & ALIGN_MASK;
        writeQ  <= startWrite;
        beQ     <= startBe;
        wordsQ  <= startWords;
        wordIdx <= '0;
        lane    <= firstLane(startWidth, startBe);
        wBuf    <= wrData;
        rBuf    <= 32'd0;
      end else if (stb.beatEnd) begin
        if (!writeQ) rBuf <= wordEnd ? 32'd0 : rNext;
        if (nextFound) begin
          lane <= nextLane;
        end else begin
          lane    <= firstL;
          wordIdx <= wordIdx + CNT_W'(1);
          if (writeQ) wBuf <= wrData;
        end
      end
    end
  end

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter int NUM_SPACES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int WAIT_W     = 4,
  localparam int SPACE_W   = $clog2(NUM_SPACES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2*NUM_SPACES-1:0]      cfgWidth,
  input  logic [WAIT_W*NUM_SPACES-1:0] cfgWait,
  input  logic [NUM_SPACES-1:0]        cfgRdyEn,
  input  logic [2*NUM_SPACES-1:0]      cfgMode,
  input  logic                         start,
  input  logic [SPACE_W-1:0]           startSpace,
  input  logic [ADDR_W-1:0]            startAddr,
  input  logic                         startWrite,
  input  logic [3:0]                   startBe,
  input  logic [CNT_W-1:0]             startWords,
  output logic                         busy,
  input  logic [31:0]                  wrData,
  output logic                         wrTake,
  output logic [31:0]                  rdData,
  output logic                         rdValid,
  output logic [ADDR_W-1:0]            lAddr,
  output logic                         lAddrStb,
  output logic                         lDataStb,
  output logic                         lBlast,
  output logic                         lBeatEnd,
  output logic                         lWrite,
  output logic [3:0]                   lBe,
  output logic [31:0]                  lDataOut,
  input  logic [31:0]                  lDataIn,
  input  logic                         lRdyN
);

  logic [1:0]        widthArr [NUM_SPACES];
  logic [WAIT_W-1:0] waitArr  [NUM_SPACES];
  logic [1:0]        modeArr  [NUM_SPACES];

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    assign widthArr[s] = cfgWidth[2*s +: 2];
    assign waitArr[s]  = cfgWait[WAIT_W*s +: WAIT_W];
    assign modeArr[s]  = cfgMode[2*s +: 2];
  end

  seqStrobe_t stb;
  seqStatus_t sts;
  logic       reqOk;

  assign reqOk = (startBe != 4'd0) && (startWords != '0);

  lbus_ctl #(.WAIT_W(WAIT_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqOk    (reqOk),
    .selWait  (waitArr[startSpace]),
    .selRdyEn (cfgRdyEn[startSpace]),
    .selMode  (modeArr[startSpace]),
    .lRdyN    (lRdyN),
    .sts      (sts),
    .stb      (stb),
    .busy     (busy),
    .lAddrStb (lAddrStb),
    .lDataStb (lDataStb),
    .lBlast   (lBlast),
    .lBeatEnd (lBeatEnd)
  );

  lbus_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .sts        (sts),
    .startWidth (widthArr[startSpace]),
    .startAddr  (startAddr),
    .startWrite (startWrite),
    .startBe    (startBe),
    .startWords (startWords),
    .wrData     (wrData),
    .wrTake     (wrTake),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .lAddr      (lAddr),
    .lWrite     (lWrite),
    .lBe        (lBe),
    .lDataOut   (lDataOut),
    .lDataIn    (lDataIn)
  );

endmodule

// File: rtl/lbus_seq_chk.sv
module lbus_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              lAddrStb,
  input logic              lDataStb,
  input logic              lBlast,
  input logic              lBeatEnd,
  input logic              lWrite,
  input logic              rdValid,
  input logic [ADDR_W-1:0] lAddr
);

  // R2
  start_begins_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> lAddrStb && $past(start));

  // R11
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    lAddrStb |=> lDataStb && !lAddrStb);

  // R9
  burst_continues_chk: assert property (@(posedge clk) disable iff (!rstN)
    lBeatEnd && !lBlast |=> lDataStb && !lAddrStb);

  // R12
  blast_ends_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    lBeatEnd && lBlast |=> !lDataStb);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lDataStb && $past(lDataStb) && !$past(lBeatEnd) |-> $stable(lAddr));

  // R13
  rd_after_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(lBeatEnd) && !lWrite);

endmodule

bind lbus_seq lbus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .lAddrStb (lAddrStb),
  .lDataStb (lDataStb),
  .lBlast   (lBlast),
  .lBeatEnd (lBeatEnd),
  .lWrite   (lWrite),
  .rdValid  (rdValid),
  .lAddr    (lAddr)
);

// File: tb/sim_lbus_seq.sv
module sim_lbus_seq;

  localparam int NS = 4;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [2*NS-1:0]  cfgWidth = '0;
  logic [WW*NS-1:0] cfgWait = '0;
  logic [NS-1:0]    cfgRdyEn = '0;
  logic [2*NS-1:0]  cfgMode = '0;
  logic             start = 1'b0;
  logic [1:0]       startSpace = '0;
  logic [AW-1:0]    startAddr = '0;
  logic             startWrite = 1'b0;
  logic [3:0]       startBe = '0;
  logic [CW-1:0]    startWords = '0;
  logic             busy;
  logic [31:0]      wrData = '0;
  logic             wrTake;
  logic [31:0]      rdData;
  logic             rdValid;
  logic [AW-1:0]    lAddr;
  logic             lAddrStb, lDataStb, lBlast, lBeatEnd, lWrite;
  logic [3:0]       lBe;
  logic [31:0]      lDataOut;
  logic [31:0]      lDataIn;
  logic             lRdyN = 1'b1;

  lbus_seq u0 (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgWait(cfgWait),
    .cfgRdyEn(cfgRdyEn), .cfgMode(cfgMode), .start(start),
    .startSpace(startSpace), .startAddr(startAddr), .startWrite(startWrite),
    .startBe(startBe), .startWords(startWords), .busy(busy), .wrData(wrData),
    .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid), .lAddr(lAddr),
    .lAddrStb(lAddrStb), .lDataStb(lDataStb), .lBlast(lBlast),
    .lBeatEnd(lBeatEnd), .lWrite(lWrite), .lBe(lBe), .lDataOut(lDataOut),
    .lDataIn(lDataIn), .lRdyN(lRdyN)
  );

  int total = 0;
  int bad = 0;

  logic [7:0]  devMem [0:255];
  logic [31:0] wrWords [0:15];
  logic [15:0] eAddr [0:63];
  logic [3:0]  eBe [0:63];
  logic [31:0] eData [0:63];
  bit          eNew [0:63];
  bit          eBlast [0:63];
  logic [31:0] eRd [0:15];
  int eN = 0, eCyc = 1, bIdx = 0, rIdx = 0, widx = 0, cyc = 0, rdyDelay = 0;
  bit takeSeen = 0, sawAddr = 0;
  string tagData = "R3", tagPhase = "R9", tagWait = "R7";

  assign lDataIn = {devMem[lAddr[7:0] + 8'd3], devMem[lAddr[7:0] + 8'd2],
                    devMem[lAddr[7:0] + 8'd1], devMem[lAddr[7:0]]};

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // bus-side device model and observer
  always @(negedge clk) begin
    if (takeSeen) begin
      widx++;
      wrData = wrWords[widx % 16];
    end
    lRdyN = lDataStb ? !(cyc >= rdyDelay) : 1'b1;
    #1;
    takeSeen = wrTake;
    if (lAddrStb) sawAddr = 1;
    if (lDataStb && lBeatEnd) begin
      if (bIdx < eN) begin
        chk(lAddr == eAddr[bIdx], tagData, "beat addr", 32'(lAddr), 32'(eAddr[bIdx]));
        chk(lBe == eBe[bIdx], tagData, "beat be", 32'(lBe), 32'(eBe[bIdx]));
        if (lWrite) chk(lDataOut == eData[bIdx], tagData, "beat wdata", lDataOut, eData[bIdx]);
        chk(lBlast == eBlast[bIdx], "R12", "burst-last", 32'(lBlast), 32'(eBlast[bIdx]));
        chk(sawAddr == eNew[bIdx], tagPhase, "new addr phase", 32'(sawAddr), 32'(eNew[bIdx]));
        chk(cyc + 1 == eCyc, tagWait, "beat cycles", 32'(cyc + 1), 32'(eCyc));
      end else begin
        chk(0, tagData, "extra beat index", 32'(bIdx), 32'(eN));
      end
      if (lWrite)
        for (int i = 0; i < 4; i++)
          if (lBe[i]) devMem[lAddr[7:0] + 8'(i)] = lDataOut[8*i +: 8];
      bIdx++;
      sawAddr = 0;
      cyc = 0;
    end else if (lDataStb) begin
      cyc++;
    end else begin
      cyc = 0;
    end
    if (rdValid) begin
      if (rIdx < 16) chk(rdData == eRd[rIdx], "R13", "read word", rdData, eRd[rIdx]);
      rIdx++;
    end
  end

  task automatic runXfer(int sp, int w, int bm, int wt, bit rdyEn, int d,
                         logic [15:0] addr, bit wr, logic [3:0] be, int words);
    int bytes, nb, inPh, n;
    logic [15:0] prev, a, wa;
    logic [3:0] m;
    bit nw;
    bytes = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    nb = 4 / bytes;
    for (int s = 0; s < NS; s++) begin
      if (s == sp) begin
        cfgWidth[2*s +: 2] = 2'(w);
        cfgWait[WW*s +: WW] = WW'(wt);
        cfgRdyEn[s] = rdyEn;
        cfgMode[2*s +: 2] = 2'(bm);
      end else begin
        cfgWidth[2*s +: 2] = 2'((w + 1) % 3);
        cfgWait[WW*s +: WW] = WW'(wt + 2);
        cfgRdyEn[s] = !rdyEn;
        cfgMode[2*s +: 2] = 2'((bm + 1) % 3);
      end
    end
    tagData = (w < 2 && be != 4'hF) ? "R6" : (w == 0) ? "R5" : (w == 1) ? "R4" : "R3";
    tagPhase = (bm == 0) ? "R11" : (bm == 1) ? "R10" : "R9";
    tagWait = rdyEn ? "R8" : "R7";
    rdyDelay = d;
    eCyc = ((rdyEn && d > wt) ? d : wt) + 1;
    for (int k = 0; k < 16; k++) wrWords[k] = 32'h9E3779B9 * (k + 1) + {addr, addr};
    eN = 0; inPh = 0; prev = '0;
    for (int wd = 0; wd < words; wd++) begin
      wa = 16'(((addr >> 2) + wd) << 2);
      eRd[wd] = '0;
      for (int i = 0; i < 4; i++)
        if (be[i]) eRd[wd][8*i +: 8] = devMem[wa[7:0] + 8'(i)];
      for (int j = 0; j < nb; j++) begin
        m = 4'((be >> (j * bytes)) & ((1 << bytes) - 1));
        if (m == 0) continue;
        a = wa + 16'(j * bytes);
        nw = (eN == 0) || (bm == 0) || (bm == 1 && inPh == 4) || (a != prev + 16'(bytes));
        if (eN > 0) eBlast[eN - 1] = nw;
        eNew[eN] = nw;
        inPh = nw ? 1 : inPh + 1;
        eAddr[eN] = a;
        eBe[eN] = m;
        eData[eN] = (wrWords[wd] >> (8 * j * bytes)) &
                    ((bytes == 4) ? 32'hFFFFFFFF : ((32'd1 << (8 * bytes)) - 1));
        prev = a;
        eN++;
      end
    end
    eBlast[eN - 1] = 1;
    bIdx = 0; rIdx = 0; widx = 0; takeSeen = 0; sawAddr = 0;
    wrData = wrWords[0];
    @(negedge clk);
    start = 1; startSpace = 2'(sp); startAddr = addr; startWrite = wr;
    startBe = be; startWords = CW'(words);
    @(negedge clk);
    start = 0;
    n = 0;
    while (busy && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(bIdx == eN, tagData, "beat count", 32'(bIdx), 32'(eN));
    if (!wr) chk(rIdx == words, "R13", "read word count", 32'(rIdx), 32'(words));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog cycles=150000 exp=done earlier");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [3:0] beList [0:5];
  bit quiet;

  initial begin
    for (int i = 0; i < 256; i++) devMem[i] = 8'(i * 7 + 3);
    beList[0] = 4'hF; beList[1] = 4'h5; beList[2] = 4'h6;
    beList[3] = 4'h8; beList[4] = 4'h3; beList[5] = 4'hC;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", 32'(busy), 0);
    chk(lAddrStb == 0 && lDataStb == 0 && lBeatEnd == 0, "R1", "strobes",
        {29'd0, lAddrStb, lDataStb, lBeatEnd}, 0);
    chk(rdValid == 0 && wrTake == 0, "R1", "rdValid/wrTake", {30'd0, rdValid, wrTake}, 0);
    rstN = 1;
    @(negedge clk);
    // R2 rejected starts
    for (int t = 0; t < 2; t++) begin
      start = 1; startBe = (t == 0) ? 4'h0 : 4'hF; startWords = (t == 0) ? 8'd2 : 8'd0;
      startWrite = 1;
      @(negedge clk);
      start = 0;
      quiet = 1;
      repeat (6) begin
        @(negedge clk);
        if (busy || lAddrStb || lDataStb) quiet = 0;
      end
      chk(quiet, "R2", "ignored start quiet", 32'(quiet), 1);
    end
    // sweep: width x burst x byte enables x direction
    for (int w = 0; w < 3; w++)
      for (int bm = 0; bm < 3; bm++)
        for (int bi = 0; bi < 6; bi++)
          for (int wr = 0; wr < 2; wr++)
            runXfer((w * 3 + bm + bi) % 4, w, bm, (bi + w) % 3, bit'(bi % 2),
                    (bi % 2 == 1) ? (bi % 3) : 9, 16'(16 * bi + 3), bit'(wr),
                    beList[bi], 3);
    // R8: ready later than internal count
    runXfer(1, 2, 2, 1, 1, 4, 16'h0080, 1, 4'hF, 2);
    runXfer(2, 1, 2, 0, 1, 3, 16'h0090, 0, 4'hF, 2);
    // R7: ready disabled, held high long, ignored
    runXfer(3, 0, 2, 2, 0, 12, 16'h00A0, 0, 4'hF, 2);
    // R9 and R10: long bursts on the 8-bit bus
    runXfer(0, 0, 2, 0, 0, 0, 16'h00B0, 1, 4'hF, 4);
    runXfer(1, 0, 1, 0, 0, 0, 16'h00C0, 1, 4'hF, 4);
    runXfer(2, 1, 1, 1, 0, 0, 16'h00D0, 0, 4'hF, 5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule